// File: doc/BRIEF.md
# UART Interrupt Combiner with FIFO Trigger Levels

This block produces every interrupt source of one UART and merges them onto a single interrupt line. It watches the transmit and receive FIFO fill counts against two programmable trigger levels. Each level is a fraction of the FIFO depth. It also takes single-cycle pulses from the receiver for framing, parity, break and overrun errors, plus a receive idle-timeout pulse. Every source sets a sticky raw status bit. A mask register selects which raw bits reach the masked status, and the masked status drives the interrupt line.

Software services the interrupt by reading the masked status. It then writes ones to the clear port for the bits it has handled. A level source whose condition still holds sets its bit again at once. The receive timeout counts only while the RX FIFO holds data that has not reached the receive trigger level. This lets a lone character raise an interrupt without waiting for the FIFO to fill.

Top module: `uart_irq_combiner`

## Requirements
- R1: After reset the raw status, the mask and the interrupt line are all zero. Both trigger level selects reset to code 2 (one half).
- R2: The level select codes 0, 1, 2, 3 and 4 give thresholds of 1/8, 1/4, 1/2, 3/4 and 7/8 of DEPTH. With DEPTH 32 these are 4, 8, 16, 24 and 28 entries. Codes 5 to 7 act as code 2. A write on `lvl_we` loads both selects and takes effect from the next cycle.
- R3: Raw bit 0 (RX level) is set at a clock edge when `rx_fill` is at or above the RX threshold.
- R4: Raw bit 1 (TX level) is set at a clock edge when `tx_fill` is at or below the TX threshold.
- R5: Raw bit 2 (RX timeout) is set when `rx_idle_timeout` is high and `rx_fill` is nonzero and below the RX threshold. Otherwise the pulse is ignored.
- R6: Raw bits 3, 4, 5 and 6 are set by pulses on `err_frame`, `err_parity`, `err_break` and `err_overrun`, in that order.
- R7: A raw bit, once set, stays set until it is cleared.
- R8: When `clr_we` is high, each 1 in `clr_wdata` clears that raw bit at the clock edge. Each 0 leaves its bit unchanged.
- R9: When a set condition and a clear of the same bit occur in the same cycle, the bit ends up set.
- R10: `masked_status` equals the raw status AND the mask. A write on `mask_we` loads the mask from `mask_wdata`.
- R11: `irq` is high exactly when `masked_status` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_fill | input | CNT_W | Transmit FIFO fill count, 0..DEPTH |
| rx_fill | input | CNT_W | Receive FIFO fill count, 0..DEPTH |
| rx_idle_timeout | input | 1 | Receive idle-timeout pulse |
| err_frame | input | 1 | Framing error pulse |
| err_parity | input | 1 | Parity error pulse |
| err_break | input | 1 | Break detected pulse |
| err_overrun | input | 1 | Receive overrun pulse |
| lvl_we | input | 1 | Load both trigger level selects |
| tx_lvl_sel | input | 3 | TX trigger level code |
| rx_lvl_sel | input | 3 | RX trigger level code |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 7 | New mask value |
| clr_we | input | 1 | Clear strobe |
| clr_wdata | input | 7 | Write-one-to-clear bit pattern |
| raw_status | output | 7 | Sticky raw source bits |
| masked_status | output | 7 | Raw status AND mask |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions rely on the error and timeout inputs being pulses that the receiver drives on its own. They also rely on the fill counts never exceeding DEPTH. The random stimulus keeps both fill counts within 0..DEPTH. It draws level codes from the full 3-bit range, so the out-of-range codes are exercised too. Error, timeout and clear strobes are raised with moderate probability, so set and clear often land in the same cycle. Directed passes walk every level code across its exact threshold, and they also target the idle-timeout qualification.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC      = 7;
    localparam int SRC_RXLVL = 0;
    localparam int SRC_TXLVL = 1;
    localparam int SRC_RXTO  = 2;
    localparam int SRC_FRM   = 3;
    localparam int SRC_PAR   = 4;
    localparam int SRC_BRK   = 5;
    localparam int SRC_OVR   = 6;

    typedef logic [2:0] lvl_code_t;
    localparam lvl_code_t LVL_RESET = 3'd2;

    // Trigger level in eighths of the FIFO depth
    function automatic int lvl_eighths(input lvl_code_t code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_level_cmp.sv
module uart_irq_level_cmp
    import uart_irq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter bit RX_SIDE = 1'b1
) (
    input  lvl_code_t        code,
    input  logic [CNT_W-1:0] fill,
    output logic             hit,
    output logic             under
);
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr   = CNT_W'((DEPTH * lvl_eighths(code)) / 8);
        under = (fill < thr);
    end

    generate
        if (RX_SIDE) begin : g_rx
            assign hit = (fill >= thr);
        end else begin : g_tx
            assign hit = (fill <= thr);
        end
    endgenerate
endmodule

// File: rtl/uart_irq_w1c_cell.sv
module uart_irq_w1c_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl_we,
    input  lvl_code_t       tx_lvl_in,
    input  lvl_code_t       rx_lvl_in,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_in,
    output lvl_code_t       tx_lvl_q,
    output lvl_code_t       rx_lvl_q,
    output logic [NSRC-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_lvl_q <= LVL_RESET;
            rx_lvl_q <= LVL_RESET;
        end else if (lvl_we) begin
            tx_lvl_q <= tx_lvl_in;
            rx_lvl_q <= rx_lvl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_in;
    end
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_fill,
    input  logic [CNT_W-1:0] rx_fill,
    input  logic             rx_idle_timeout,
    input  logic             err_frame,
    input  logic             err_parity,
    input  logic             err_break,
    input  logic             err_overrun,
    input  logic             lvl_we,
    input  logic [2:0]       tx_lvl_sel,
    input  logic [2:0]       rx_lvl_sel,
    input  logic             mask_we,
    input  logic [NSRC-1:0]  mask_wdata,
    input  logic             clr_we,
    input  logic [NSRC-1:0]  clr_wdata,
    output logic [NSRC-1:0]  raw_status,
    output logic [NSRC-1:0]  masked_status,
    output logic             irq
);
    lvl_code_t       tx_lvl_q, rx_lvl_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic            rx_hit, rx_under, tx_hit, tx_under;

    uart_irq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_we    (lvl_we),
        .tx_lvl_in (tx_lvl_sel),
        .rx_lvl_in (rx_lvl_sel),
        .mask_we   (mask_we),
        .mask_in   (mask_wdata),
        .tx_lvl_q  (tx_lvl_q),
        .rx_lvl_q  (rx_lvl_q),
        .mask_q    (mask_q)
    );

    uart_irq_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RX_SIDE(1'b1)) u_rx_cmp (
        .code  (rx_lvl_q),
        .fill  (rx_fill),
        .hit   (rx_hit),
        .under (rx_under)
    );

    uart_irq_level_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RX_SIDE(1'b0)) u_tx_cmp (
        .code  (tx_lvl_q),
        .fill  (tx_fill),
        .hit   (tx_hit),
        .under (tx_under)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[SRC_RXLVL] = rx_hit;
        set_vec[SRC_TXLVL] = tx_hit;
        set_vec[SRC_RXTO]  = rx_idle_timeout && (rx_fill != '0) && rx_under;
        set_vec[SRC_FRM]   = err_frame;
        set_vec[SRC_PAR]   = err_parity;
        set_vec[SRC_BRK]   = err_break;
        set_vec[SRC_OVR]   = err_overrun;
        clr_vec            = clr_we ? clr_wdata : '0;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            uart_irq_w1c_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (set_vec[i]),
                .clr   (clr_vec[i]),
                .q     (raw_status[i])
            );
        end
    endgenerate

    assign masked_status = raw_status & mask_q;
    assign irq           = |masked_status;
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
    import uart_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            err_frame,
    input logic            err_overrun,
    input logic            clr_we,
    input logic [NSRC-1:0] clr_wdata,
    input logic [NSRC-1:0] raw_status,
    input logic [NSRC-1:0] masked_status,
    input logic            irq
);
    // R6
    frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> raw_status[SRC_FRM]);

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun && clr_we && clr_wdata[SRC_OVR]) |=> raw_status[SRC_OVR]);

    // R8
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_wdata[SRC_FRM] && !err_frame) |=> !raw_status[SRC_FRM]);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[SRC_OVR] && !(clr_we && clr_wdata[SRC_OVR])) |=> raw_status[SRC_OVR]);

    // R10
    masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0);

    // R11
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_status != '0));
endmodule

bind uart_irq_combiner uart_irq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_frame     (err_frame),
    .err_overrun   (err_overrun),
    .clr_we        (clr_we),
    .clr_wdata     (clr_wdata),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq)
);

// File: tb/uart_irq_combiner_tb.sv
`timescale 1ns/1ps
module uart_irq_combiner_tb;
    localparam int DEPTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NS    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] tx_fill, rx_fill;
    logic rx_idle_timeout, err_frame, err_parity, err_break, err_overrun;
    logic lvl_we, mask_we, clr_we;
    logic [2:0] tx_lvl_sel, rx_lvl_sel;
    logic [NS-1:0] mask_wdata, clr_wdata;
    logic [NS-1:0] raw_status, masked_status;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [NS-1:0] m_raw, m_mask;
    logic [2:0]    m_txs, m_rxs;

    always #2 clk = ~clk;

    uart_irq_combiner #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_fill(tx_fill), .rx_fill(rx_fill),
        .rx_idle_timeout(rx_idle_timeout), .err_frame(err_frame),
        .err_parity(err_parity), .err_break(err_break), .err_overrun(err_overrun),
        .lvl_we(lvl_we), .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we),
        .clr_wdata(clr_wdata), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq)
    );

    function automatic int thr(input logic [2:0] c);
        case (c)
            3'd0:    return DEPTH / 8;
            3'd1:    return DEPTH / 4;
            3'd3:    return (DEPTH * 3) / 4;
            3'd4:    return (DEPTH * 7) / 8;
            default: return DEPTH / 2;
        endcase
    endfunction

    function automatic logic [NS-1:0] set_model();
        logic [NS-1:0] s;
        int rt, tt;
        rt = thr(m_rxs);
        tt = thr(m_txs);
        s[0] = int'(rx_fill) >= rt;
        s[1] = int'(tx_fill) <= tt;
        s[2] = rx_idle_timeout && rx_fill != 0 && int'(rx_fill) < rt;
        s[3] = err_frame;
        s[4] = err_parity;
        s[5] = err_break;
        s[6] = err_overrun;
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_idle_timeout = 0; err_frame = 0; err_parity = 0; err_break = 0;
        err_overrun = 0; lvl_we = 0; mask_we = 0; clr_we = 0;
        clr_wdata = '0; mask_wdata = '0;
    endtask

    // Apply current inputs for one edge, advance the model, compare at negedge
    task automatic tick();
        logic [NS-1:0] s, c;
        s = set_model();
        c = clr_we ? clr_wdata : '0;
        @(posedge clk);
        m_raw = (m_raw & ~c) | s;
        if (mask_we) m_mask = mask_wdata;
        if (lvl_we) begin
            m_txs = tx_lvl_sel;
            m_rxs = rx_lvl_sel;
        end
        @(negedge clk);
        chk(raw_status[0] == m_raw[0], "R3 rx level bit", raw_status, m_raw);
        chk(raw_status[1] == m_raw[1], "R4 tx level bit", raw_status, m_raw);
        chk(raw_status[2] == m_raw[2], "R5 timeout bit", raw_status, m_raw);
        chk(raw_status[6:3] == m_raw[6:3], "R6 error bits", raw_status, m_raw);
        chk(masked_status == (m_raw & m_mask), "R10 masked", masked_status, m_raw & m_mask);
        chk(irq == |(m_raw & m_mask), "R11 irq", irq, |(m_raw & m_mask));
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        tx_fill = CNT_W'(DEPTH);
        rx_fill = '0;
        tx_lvl_sel = 3'd2; rx_lvl_sel = 3'd2;
        m_raw = '0; m_mask = '0; m_txs = 3'd2; m_rxs = 3'd2;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(raw_status == '0, "R1 raw reset", raw_status, 0);
        chk(masked_status == '0 && irq == 1'b0, "R1 irq reset", irq, 0);
        rst_n = 1'b1;
        // R1: default RX level is one half
        rx_fill = CNT_W'(DEPTH / 2 - 1);
        tick();
        chk(raw_status[0] == 1'b0, "R1 default level below", raw_status[0], 0);
        rx_fill = CNT_W'(DEPTH / 2);
        tick();
        chk(raw_status[0] == 1'b1, "R1 default level at", raw_status[0], 1);

        // R2: walk every code across its threshold
        for (int c = 0; c < 8; c++) begin
            lvl_we = 1; rx_lvl_sel = 3'(c); tx_lvl_sel = 3'(c);
            tick();
            rx_fill = CNT_W'(thr(3'(c)) - 1);
            clr_we = 1; clr_wdata = '1;
            tick();
            chk(raw_status[0] == 1'b0, "R2 below threshold", raw_status[0], 0);
            rx_fill = CNT_W'(thr(3'(c)));
            tick();
            chk(raw_status[0] == 1'b1, "R2 at threshold", raw_status[0], 1);
            tx_fill = CNT_W'(thr(3'(c)) + 1);
            clr_we = 1; clr_wdata = '1;
            rx_fill = '0;
            tick();
            chk(raw_status[1] == 1'b0, "R4 tx above threshold", raw_status[1], 0);
            tx_fill = CNT_W'(thr(3'(c)));
            tick();
            chk(raw_status[1] == 1'b1, "R4 tx at threshold", raw_status[1], 1);
            tx_fill = CNT_W'(DEPTH);
        end

        // R5: timeout ignored with empty FIFO, taken with one entry
        lvl_we = 1; rx_lvl_sel = 3'd2; tx_lvl_sel = 3'd2;
        clr_we = 1; clr_wdata = '1;
        tick();
        rx_fill = '0; rx_idle_timeout = 1;
        tick();
        chk(raw_status[2] == 1'b0, "R5 empty ignored", raw_status[2], 0);
        rx_fill = CNT_W'(1); rx_idle_timeout = 1;
        tick();
        chk(raw_status[2] == 1'b1, "R5 single char", raw_status[2], 1);

        // R7: error bit stays set over idle cycles
        rx_fill = '0;
        err_break = 1;
        tick();
        repeat (3) tick();
        chk(raw_status[5] == 1'b1, "R7 sticky", raw_status[5], 1);
        // R8: zero clear pattern does nothing, a one clears
        clr_we = 1; clr_wdata = 7'b0;
        tick();
        chk(raw_status[5] == 1'b1, "R8 zero no effect", raw_status[5], 1);
        clr_we = 1; clr_wdata = 7'b010_0000;
        tick();
        chk(raw_status[5] == 1'b0, "R8 one clears", raw_status[5], 0);
        // R9: set and clear together leave the bit set
        err_parity = 1; clr_we = 1; clr_wdata = 7'b001_0000;
        tick();
        chk(raw_status[4] == 1'b1, "R9 set wins", raw_status[4], 1);
        // R10 R11: mask gating
        mask_we = 1; mask_wdata = 7'b001_0000;
        tick();
        chk(irq == 1'b1, "R11 masked source", irq, 1);
        mask_we = 1; mask_wdata = 7'b100_0000;
        tick();
        chk(masked_status == '0 && irq == 1'b0, "R10 masked off", masked_status, 0);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            tx_fill = CNT_W'($urandom_range(DEPTH, 0));
            rx_fill = CNT_W'($urandom_range(DEPTH, 0));
            rx_idle_timeout = ($urandom_range(3, 0) == 0);
            err_frame   = ($urandom_range(7, 0) == 0);
            err_parity  = ($urandom_range(7, 0) == 0);
            err_break   = ($urandom_range(7, 0) == 0);
            err_overrun = ($urandom_range(7, 0) == 0);
            lvl_we = ($urandom_range(15, 0) == 0);
            tx_lvl_sel = 3'($urandom_range(7, 0));
            rx_lvl_sel = 3'($urandom_range(7, 0));
            mask_we = ($urandom_range(7, 0) == 0);
            mask_wdata = NS'($urandom);
            clr_we = ($urandom_range(2, 0) == 0);
            clr_wdata = NS'($urandom);
            tick();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule